// File: doc/BRIEF.md
# Fast External Strobe Transfer Bridge

This block sits beside a CPU data bus and an endpoint FIFO. It turns one CPU data-move cycle at a fixed register address into a byte transfer between the FIFO and external logic. When the CPU reads that address, the block pops the FIFO head and returns it to the CPU. In the same access it puts the byte on the external data pins and pulses the outbound strobe. When the CPU writes that address, the CPU's data is not taken. Instead, the byte present on the external data pins is pushed into the FIFO while the inbound strobe pulses.

Every transfer spans two clock cycles, which are called the first and second cycle after the accepting edge. Four configuration bits choose the strobe behaviour. Each strobe has its own polarity bit and its own timing bit. The timing bit selects whether the strobe covers both cycles or only the second one. The external data bus is presented as pad-side signals: output data, output enable and input data. A bidirectional pad joins them. Two sticky flags record an access that found the FIFO empty on a read, or full on a write. Only reset clears them.

Top module: `fast_strobe_bridge`

## Requirements
- R1: After reset both strobes sit at their idle level for the default configuration (polarity bit 0, so the pin is 1). There is no pop and no push, the bus output enable is 0, and both error flags are 0.
- R2: A request to FIFO_ADDR with cpu_we=0 and a non-empty FIFO is accepted on a clock edge. In the first cycle after that edge, fifo_pop is 1 for that one cycle only, and cpu_rdata holds the FIFO head byte. From that cycle, ext_dout also carries the head byte.
- R3: A request to FIFO_ADDR with cpu_we=1 and room in the FIFO makes fifo_push 1 in the second cycle only. In that cycle fifo_wr_data equals ext_din, which the FIFO takes on the edge that ends the inbound strobe. A push still landing counts as taken room: when fifo_afull is 1 in that case, the access counts as full.
- R4: Timing bit 0 (cfg_wstb_late / cfg_rstb_late) keeps the strobe active in both cycles of a successful transfer. Timing bit 1 makes it active only in the second cycle.
- R5: Polarity bit 0 (cfg_wstb_high / cfg_rstb_high) makes a strobe active-low with idle 1. Polarity bit 1 makes it active-high with idle 0. The pin follows the bit from the cycle after the bit changes.
- R6: ext_doe is 1 exactly in the cycles where the outbound strobe is active. At every other time it is 0, including during writes.
- R7: A read access while the FIFO is empty gives no strobe and no pop, and cpu_rdata becomes 0. err_underflow is set and stays 1. FIFO status is judged at the accepting edge, so a push landing on that same edge is not yet visible.
- R8: A write access while the FIFO is full gives no strobe and no push. err_overflow is set and stays 1.
- R9: A request to any address other than FIFO_ADDR causes no strobe, no pop and no push.
- R10: A new request may be accepted in the second cycle of a transfer, so transfers can follow back to back. The two strobes are never active in the same cycle, and pop and push never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU bus access present this cycle |
| cpu_we | input | 1 | 1 = CPU write, 0 = CPU read |
| cpu_addr | input | ADDR_W | CPU bus address |
| cpu_rdata | output | DATA_W | Byte returned to the CPU for a FIFO read |
| fifo_rd_data | input | DATA_W | FIFO head byte (first-word fall-through) |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_pop | output | 1 | Remove the head byte at the next edge |
| fifo_full | input | 1 | FIFO has no free slot |
| fifo_afull | input | 1 | FIFO has exactly one free slot |
| fifo_push | output | 1 | Store fifo_wr_data at the next edge |
| fifo_wr_data | output | DATA_W | Byte to store |
| ext_dout | output | DATA_W | External bus output data |
| ext_doe | output | 1 | External bus output enable |
| ext_din | input | DATA_W | External bus input data |
| ext_wstb | output | 1 | Outbound strobe (FIFO to pins) |
| ext_rstb | output | 1 | Inbound strobe (pins to FIFO) |
| cfg_wstb_high | input | 1 | Outbound strobe polarity, 1 = active-high |
| cfg_rstb_high | input | 1 | Inbound strobe polarity, 1 = active-high |
| cfg_wstb_late | input | 1 | Outbound strobe only in second cycle |
| cfg_rstb_late | input | 1 | Inbound strobe only in second cycle |
| err_underflow | output | 1 | Sticky: read met an empty FIFO |
| err_overflow | output | 1 | Sticky: write met a full FIFO |

## Verification
The bench builds the block with an 8-bit address and FIFO_ADDR of 8'hA5. It places the block next to a four-entry FIFO model. The small depth lets a handful of back-to-back writes reach the full state, where a push still landing and the almost-full input must combine correctly. Short address decoding lets random non-matching addresses fall close to the matching one. Random polarity and timing settings cover all four strobe variants in both directions.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;

  localparam int NUM_STB = 2;
  localparam int STB_OUT = 0;  // FIFO to pins
  localparam int STB_IN  = 1;  // pins to FIFO

  function automatic logic pin_level(logic active, logic high);
    return active ? high : ~high;
  endfunction
endpackage

// File: rtl/fsb_decode.sv
module fsb_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = '0
) (
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              hit
);
  assign hit = cpu_req && (cpu_addr == FIFO_ADDR);
endmodule

// File: rtl/fsb_seq.sv
module fsb_seq
  import fsb_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               hit,
  input  logic               cpu_we,
  input  logic               fifo_empty,
  input  logic               fifo_full,
  input  logic               fifo_afull,
  input  logic [NUM_STB-1:0] cfg_late,
  output logic [NUM_STB-1:0] act_next,
  output logic               rd_capture,
  output logic               rd_ok,
  output logic               fifo_pop,
  output logic               fifo_push,
  output logic               err_underflow,
  output logic               err_overflow
);
  phase_e ph_q;
  logic   dir_in_q, ok_q, pop_q, push_q, under_q, over_q;
  logic   accept, room, ok;

  // a new access may start in any cycle but the first of a transfer
  assign accept = hit && (ph_q != PH_FIRST);
  // a push landing on the accepting edge consumes one slot
  assign room   = !(fifo_full || (push_q && fifo_afull));
  assign ok     = cpu_we ? room : !fifo_empty;

  always_comb begin
    act_next = '0;
    if (accept && ok) begin
      if (cpu_we) act_next[STB_IN]  = !cfg_late[STB_IN];
      else        act_next[STB_OUT] = !cfg_late[STB_OUT];
    end
    if (ph_q == PH_FIRST && ok_q) begin
      if (dir_in_q) act_next[STB_IN]  = 1'b1;
      else          act_next[STB_OUT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      dir_in_q <= 1'b0;
      ok_q     <= 1'b0;
      pop_q    <= 1'b0;
      push_q   <= 1'b0;
      under_q  <= 1'b0;
      over_q   <= 1'b0;
    end else begin
      if (accept)                ph_q <= PH_FIRST;
      else if (ph_q == PH_FIRST) ph_q <= PH_SECOND;
      else                       ph_q <= PH_IDLE;
      if (accept) begin
        dir_in_q <= cpu_we;
        ok_q     <= ok;
      end
      pop_q   <= accept && !cpu_we && ok;
      push_q  <= (ph_q == PH_FIRST) && dir_in_q && ok_q;
      under_q <= under_q || (accept && !cpu_we && !ok);
      over_q  <= over_q  || (accept &&  cpu_we && !ok);
    end
  end

  assign rd_capture    = accept && !cpu_we;
  assign rd_ok         = ok;
  assign fifo_pop      = pop_q;
  assign fifo_push     = push_q;
  assign err_underflow = under_q;
  assign err_overflow  = over_q;
endmodule

// File: rtl/fsb_pins.sv
module fsb_pins
  import fsb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_STB-1:0] act_next,
  input  logic [NUM_STB-1:0] cfg_high,
  input  logic               rd_capture,
  input  logic               rd_ok,
  input  logic [DATA_W-1:0]  fifo_rd_data,
  output logic [NUM_STB-1:0] stb_pin,
  output logic               ext_doe,
  output logic [DATA_W-1:0]  ext_dout,
  output logic [DATA_W-1:0]  cpu_rdata
);
  logic [NUM_STB-1:0] stb_q;
  logic [DATA_W-1:0]  byte_q;
  logic               doe_q;

  for (genvar ch = 0; ch < NUM_STB; ch++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb_q[ch] <= 1'b1;
      else     stb_q[ch] <= pin_level(act_next[ch], cfg_high[ch]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
      doe_q  <= 1'b0;
    end else begin
      if (rd_capture) byte_q <= rd_ok ? fifo_rd_data : '0;
      doe_q <= act_next[STB_OUT];
    end
  end

  assign stb_pin   = stb_q;
  assign ext_doe   = doe_q;
  assign ext_dout  = byte_q;
  assign cpu_rdata = byte_q;
endmodule

// File: rtl/fast_strobe_bridge.sv
module fast_strobe_bridge
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] FIFO_ADDR = 16'h7F20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] fifo_rd_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              fifo_full,
  input  logic              fifo_afull,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic [DATA_W-1:0] ext_dout,
  output logic              ext_doe,
  input  logic [DATA_W-1:0] ext_din,
  output logic              ext_wstb,
  output logic              ext_rstb,
  input  logic              cfg_wstb_high,
  input  logic              cfg_rstb_high,
  input  logic              cfg_wstb_late,
  input  logic              cfg_rstb_late,
  output logic              err_underflow,
  output logic              err_overflow
);
  logic               hit, rd_capture, rd_ok;
  logic [NUM_STB-1:0] act_next, stb_pin, cfg_high, cfg_late;

  assign cfg_high[STB_OUT] = cfg_wstb_high;
  assign cfg_high[STB_IN]  = cfg_rstb_high;
  assign cfg_late[STB_OUT] = cfg_wstb_late;
  assign cfg_late[STB_IN]  = cfg_rstb_late;

  fsb_decode #(.ADDR_W(ADDR_W), .FIFO_ADDR(FIFO_ADDR)) i_decode (
    .cpu_req (cpu_req),
    .cpu_addr(cpu_addr),
    .hit     (hit)
  );

  fsb_seq i_seq (
    .clk          (clk),
    .rst          (rst),
    .hit          (hit),
    .cpu_we       (cpu_we),
    .fifo_empty   (fifo_empty),
    .fifo_full    (fifo_full),
    .fifo_afull   (fifo_afull),
    .cfg_late     (cfg_late),
    .act_next     (act_next),
    .rd_capture   (rd_capture),
    .rd_ok        (rd_ok),
    .fifo_pop     (fifo_pop),
    .fifo_push    (fifo_push),
    .err_underflow(err_underflow),
    .err_overflow (err_overflow)
  );

  fsb_pins #(.DATA_W(DATA_W)) i_pins (
    .clk         (clk),
    .rst         (rst),
    .act_next    (act_next),
    .cfg_high    (cfg_high),
    .rd_capture  (rd_capture),
    .rd_ok       (rd_ok),
    .fifo_rd_data(fifo_rd_data),
    .stb_pin     (stb_pin),
    .ext_doe     (ext_doe),
    .ext_dout    (ext_dout),
    .cpu_rdata   (cpu_rdata)
  );

  // inbound byte is taken straight from the pad, stored on the strobe's closing edge
  assign fifo_wr_data = ext_din;
  assign ext_wstb     = stb_pin[STB_OUT];
  assign ext_rstb     = stb_pin[STB_IN];
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker (
  input logic clk,
  input logic rst,
  input logic fifo_pop,
  input logic fifo_push,
  input logic fifo_empty,
  input logic ext_doe,
  input logic ext_wstb,
  input logic ext_rstb,
  input logic cfg_wstb_high,
  input logic cfg_rstb_high,
  input logic err_underflow,
  input logic err_overflow
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> $past(!fifo_empty)); // R2
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push); // R3
  AST_PUSH_STROBED: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> (ext_rstb == $past(cfg_rstb_high))); // R3
  AST_BUS_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    ext_doe |-> (ext_wstb == $past(cfg_wstb_high))); // R6
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_underflow) |-> err_underflow); // R7
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err_overflow) |-> err_overflow); // R8
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
    !((ext_wstb == $past(cfg_wstb_high)) && (ext_rstb == $past(cfg_rstb_high)))); // R10
  AST_NO_POP_PUSH: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && fifo_push)); // R10
endmodule

bind fast_strobe_bridge fsb_checker i_fsb_checker (.*);

// File: tb/test_fast_strobe_bridge.sv
module test_fast_strobe_bridge;
  localparam int AW = 8;
  localparam logic [AW-1:0] FA = 8'hA5;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_rdata, fifo_rd_data, fifo_wr_data, ext_dout, ext_din = '0;
  logic fifo_empty, fifo_full, fifo_afull, fifo_pop, fifo_push, ext_doe;
  logic ext_wstb, ext_rstb, err_underflow, err_overflow;
  logic cfg_wstb_high = 0, cfg_rstb_high = 0, cfg_wstb_late = 0, cfg_rstb_late = 0;

  fast_strobe_bridge #(.ADDR_W(AW), .DATA_W(8), .FIFO_ADDR(FA)) i_fast_strobe_bridge (.*);

  always #4 clk = ~clk;

  // environment FIFO, first-word fall-through
  logic [7:0] fmem [DEPTH];
  int frp = 0, fwp = 0, fcnt = 0;
  assign fifo_empty   = (fcnt == 0);
  assign fifo_full    = (fcnt == DEPTH);
  assign fifo_afull   = (fcnt == DEPTH - 1);
  assign fifo_rd_data = fmem[frp];
  initial for (int i = 0; i < DEPTH; i++) fmem[i] = '0;
  always @(posedge clk) begin
    if (rst) begin
      frp <= 0; fwp <= 0; fcnt <= 0;
    end else begin
      if (fifo_push && fcnt < DEPTH) begin
        fmem[fwp] <= fifo_wr_data;
        fwp <= (fwp + 1) % DEPTH;
      end
      if (fifo_pop && fcnt > 0) frp <= (frp + 1) % DEPTH;
      fcnt <= fcnt + ((fifo_push && fcnt < DEPTH) ? 1 : 0) - ((fifo_pop && fcnt > 0) ? 1 : 0);
    end
  end

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] expq[$];
  bit pend = 0, exp_under = 0, exp_over = 0;

  function automatic logic lvl(logic active, logic high);
    return active ? high : ~high;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pair();
    chk("R10 both strobes active",
        {31'd0, (ext_wstb == cfg_wstb_high) && (ext_rstb == cfg_rstb_high)}, 0);
  endtask

  // one access; enters and returns at a falling edge
  task automatic access(input bit we, input bit hit, input logic [7:0] dval,
                        input bit late, input bit wpol, input bit rpol);
    bit ok;
    logic [7:0] eb;
    int vis;
    cpu_req = 1; cpu_we = we;
    cpu_addr = hit ? FA : FA + 8'd1 + 8'($urandom % 254);
    cfg_wstb_late = late; cfg_rstb_late = late;
    cfg_wstb_high = wpol; cfg_rstb_high = rpol;
    vis = expq.size() - (pend ? 1 : 0);
    ok = hit && (we ? (expq.size() < DEPTH) : (vis > 0));
    eb = (!we && ok) ? expq[0] : 8'h00;
    @(posedge clk); #1;
    cpu_req = 0;
    ext_din = we ? dval : 8'($urandom);
    pend = 0;
    if (ok) begin
      if (we) expq.push_back(dval);
      else void'(expq.pop_front());
    end else if (hit) begin
      if (we) exp_over = 1; else exp_under = 1;
    end
    @(negedge clk);  // first cycle
    chk_pair();
    chk("R7 underflow flag", {31'd0, err_underflow}, {31'd0, exp_under});
    chk("R8 overflow flag", {31'd0, err_overflow}, {31'd0, exp_over});
    chk("R3 no push in first cycle", {31'd0, fifo_push}, 0);
    if (!hit) begin
      chk("R9 other address pop", {31'd0, fifo_pop}, 0);
      chk("R9 other address wstb", {31'd0, ext_wstb}, {31'd0, lvl(0, wpol)});
      chk("R9 other address rstb", {31'd0, ext_rstb}, {31'd0, lvl(0, rpol)});
    end else if (!we) begin
      chk(ok ? "R2 pop pulse" : "R7 no pop when empty", {31'd0, fifo_pop}, {31'd0, ok});
      chk(ok ? "R2 cpu read data" : "R7 cpu read zero", {24'd0, cpu_rdata}, {24'd0, eb});
      chk("R4 wstb first cycle", {31'd0, ext_wstb}, {31'd0, lvl(ok && !late, wpol)});
      chk("R6 doe first cycle", {31'd0, ext_doe}, {31'd0, ok && !late});
      if (ok) chk("R2 bus data", {24'd0, ext_dout}, {24'd0, eb});
      chk("R5 rstb idle during read", {31'd0, ext_rstb}, {31'd0, lvl(0, rpol)});
    end else begin
      chk("R2 no pop on write", {31'd0, fifo_pop}, 0);
      chk(ok ? "R4 rstb first cycle" : "R8 no strobe when full",
          {31'd0, ext_rstb}, {31'd0, lvl(ok && !late, rpol)});
      chk("R6 no drive on write", {31'd0, ext_doe}, 0);
      chk("R5 wstb idle during write", {31'd0, ext_wstb}, {31'd0, lvl(0, wpol)});
    end
    @(negedge clk);  // second cycle
    chk_pair();
    chk("R2 single pop", {31'd0, fifo_pop}, 0);
    if (!hit) begin
      chk("R9 other address push", {31'd0, fifo_push}, 0);
      chk("R9 other address doe", {31'd0, ext_doe}, 0);
    end else if (!we) begin
      chk(ok ? "R4 wstb second cycle" : "R7 no strobe when empty",
          {31'd0, ext_wstb}, {31'd0, lvl(ok, wpol)});
      chk("R6 doe second cycle", {31'd0, ext_doe}, {31'd0, ok});
      if (ok) chk("R2 bus data held", {24'd0, ext_dout}, {24'd0, eb});
      chk("R3 no push on read", {31'd0, fifo_push}, 0);
    end else begin
      chk(ok ? "R3 push pulse" : "R8 no push when full", {31'd0, fifo_push}, {31'd0, ok});
      if (ok) chk("R3 push data from pins", {24'd0, fifo_wr_data}, {24'd0, dval});
      chk("R4 rstb second cycle", {31'd0, ext_rstb}, {31'd0, lvl(ok, rpol)});
      chk("R6 no drive on write", {31'd0, ext_doe}, 0);
    end
    if (we && ok) pend = 1;
  endtask

  task automatic idle(input bit wpol, input bit rpol);
    cfg_wstb_high = wpol; cfg_rstb_high = rpol;
    @(negedge clk);
    pend = 0;
    chk("R5 idle wstb level", {31'd0, ext_wstb}, {31'd0, ~wpol});
    chk("R5 idle rstb level", {31'd0, ext_rstb}, {31'd0, ~rpol});
    chk("R6 idle bus released", {31'd0, ext_doe}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_2100));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset wstb", {31'd0, ext_wstb}, 1);
    chk("R1 reset rstb", {31'd0, ext_rstb}, 1);
    chk("R1 reset pop", {31'd0, fifo_pop}, 0);
    chk("R1 reset push", {31'd0, fifo_push}, 0);
    chk("R1 reset doe", {31'd0, ext_doe}, 0);
    chk("R1 reset flags", {30'd0, err_underflow, err_overflow}, 0);

    access(0, 1, 8'h00, 0, 0, 0);                       // R7 empty read
    for (int i = 0; i < 5; i++)                         // R3 R8 fill then overflow, back to back
      access(1, 1, 8'h30 + 8'(i), 0, 0, 0);
    idle(1, 0); idle(1, 1); idle(0, 1);                 // R5 polarity follows
    for (int i = 0; i < 4; i++)                         // R2 R4 late reads, back to back
      access(0, 1, 8'h00, 1, 1, 1);
    access(0, 9'd0 == 9'd1, 8'h00, 0, 0, 0);            // R9 other address
    access(1, 0, 8'h77, 0, 0, 0);                       // R9 other address write
    access(1, 1, 8'hC3, 0, 0, 1);                       // R7 write then read on empty
    access(0, 1, 8'h00, 0, 0, 1);
    idle(0, 0);

    for (int n = 0; n < 600; n++) begin
      int bias = (n / 100) % 2 == 0 ? 65 : 35;
      bit we = ($urandom % 100) < bias;
      bit hit = ($urandom % 10) != 0;
      access(we, hit, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 5) == 0) idle(1'($urandom), 1'($urandom));
    end
    idle(0, 0);
    finish_run();
  end
endmodule